// File: doc/BRIEF.md
# Two-Pattern Scan Delay-Test Sequencer

This block applies two-pattern delay tests to a small MUX-scan chain that wraps a toy combinational circuit. A tester starts a run with a strobe and supplies the test configuration: the active chain length, the launch rule, the number of settle cycles, and the number of patterns. It then feeds one scan bit per shift cycle on a serial input and reads responses from a serial output. For each pattern the sequencer steps through three phases. First it loads the initial vector. Then it launches the transition. Then it captures the response exactly one clock after the launch.

Two launch rules are supported. With launch-by-shift, the launch is one more shift with scan enable still high, so the second vector is the first vector moved along by one cell, and scan enable falls just before the capture. With launch-by-capture, scan enable falls as soon as loading ends, and a programmable number of quiet cycles may follow so that a slow enable net can settle. After that, launch and capture are both functional clocks. After each capture, scan enable returns high. The response is shifted out while the next pattern is shifted in, and a final flush unloads the last response.

Top module: `twopat_seq`

## Requirements
- R1: After reset, and whenever no run is in progress, busy=0, done=0, scan_en=1, chain_ce=0, launch=0 and capture=0. The chain is cleared to all zeros and the active length is 1.
- R2: A start seen while idle is followed by exactly L load cycles. In each of them scan_en=1 and chain_ce=1, and the scan_in bit present in that cycle enters cell 0 at the clock edge that ends the cycle.
- R3: The launch_mode input selects the launch rule: 0 is launch-by-shift and 1 is launch-by-capture. With launch_mode=0, the cycle after loading is the launch cycle (launch=1), and it is one further shift with scan_en=1 and chain_ce=1.
- R4: In every capture cycle, capture=1, scan_en=0 and chain_ce=1, and the chain takes the functional response.
- R5: With launch_mode=1, scan_en is 0 from the end of loading onward. The latched idle count N gives N cycles with chain_ce=0, then a launch cycle that is a functional clock (launch=1, scan_en=0, chain_ce=1).
- R6: With launch_mode=0, the idle count has no effect, and launch follows loading directly.
- R7: The capture cycle is always the cycle immediately after the launch cycle.
- R8: A shift does cell[0] <= scan_in and cell[i] <= cell[i-1] over all MAX_LEN cells. A functional clock does cell[i] <= cell[(i+1) mod MAX_LEN] XOR (cell[i] AND cell[(i+2) mod MAX_LEN]). scan_out always shows cell[L-1].
- R9: After each capture that is not the last, L shift cycles follow that unload the response while loading the next pattern. A pattern count of 0 is treated as 1.
- R10: After the last capture, L flush shifts follow. In the next cycle, done=1 for exactly one cycle and busy=0.
- R11: A start, or any change on the configuration inputs, has no effect while busy=1.
- R12: The active length L is the latched pattern length, clamped so that 0 gives 1 and values above MAX_LEN give MAX_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle |
| pat_len | input | LEN_W (7) | Active chain length, clamped to 1..MAX_LEN |
| launch_mode | input | 1 | 0 launch-by-shift, 1 launch-by-capture |
| idle_cycles | input | IDLE_W (4) | Quiet cycles before a capture-style launch |
| pat_count | input | NPAT_W (4) | Number of patterns in the run (0 means 1) |
| scan_in | input | 1 | Serial scan data into cell 0 |
| scan_out | output | 1 | Serial scan data from cell L-1 |
| scan_en | output | 1 | Scan enable to the chain (1 = shift path) |
| chain_ce | output | 1 | Chain clock enable for this cycle |
| launch | output | 1 | High in the launch cycle |
| capture | output | 1 | High in the capture cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the final unload |

## Verification
The hardest situation to reach is a pattern boundary under overlap. The unload of one response and the load of the next share the same shifts, and the bits leaving at scan_out must be the functional response of the cells, including cells beyond the active length that the functional clock still mixes in. The bench keeps a bit-accurate model of all MAX_LEN cells across runs and compares scan_out in every cycle over multi-pattern runs in both launch rules. In the middle of one load it also pulses start and flips the configuration inputs, to show that the running sequence is undisturbed.

// File: rtl/twopat_pkg.sv
`timescale 1ns/1ps
package twopat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_GAP,
    ST_LAUNCH,
    ST_CAPT,
    ST_FLUSH
  } seq_state_e;

  typedef enum logic {
    LAUNCH_SHIFT = 1'b0,
    LAUNCH_CAPT  = 1'b1
  } launch_mode_e;
endpackage

// File: rtl/twopat_cell.sv
`timescale 1ns/1ps
module twopat_cell (
  input  logic clk,
  input  logic rst,
  input  logic se,
  input  logic ce,
  input  logic sd,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (ce) q <= se ? sd : d;
  end
endmodule

// File: rtl/twopat_cut.sv
`timescale 1ns/1ps
module twopat_cut #(
  parameter int W = 64
) (
  input  logic [W-1:0] cells_i,
  output logic [W-1:0] nxt_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign nxt_o[i] = cells_i[(i + 1) % W] ^ (cells_i[i] & cells_i[(i + 2) % W]);
  end
endmodule

// File: rtl/twopat_chain.sv
`timescale 1ns/1ps
module twopat_chain #(
  parameter  int MAX_LEN = 64,
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int IDX_W   = $clog2(MAX_LEN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_i,
  input  logic               capt_i,
  input  logic               scan_in,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [MAX_LEN-1:0] func_i,
  output logic [MAX_LEN-1:0] cells_o,
  output logic               scan_out
);
  logic [MAX_LEN-1:0] sdi;
  logic               ce;
  logic [IDX_W-1:0]   tap;

  assign ce = shift_i | capt_i;

  for (genvar i = 0; i < MAX_LEN; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign sdi[i] = scan_in;
    end else begin : g_body
      assign sdi[i] = cells_o[i-1];
    end
    twopat_cell u_cell (
      .clk(clk),
      .rst(rst),
      .se (shift_i),
      .ce (ce),
      .sd (sdi[i]),
      .d  (func_i[i]),
      .q  (cells_o[i])
    );
  end

  assign tap      = IDX_W'(len_i - 1'b1);
  assign scan_out = cells_o[tap];

  AST_TAP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (len_i != '0) && (len_i <= LEN_W'(MAX_LEN))); // R12
  AST_ONE_CHAIN_ACTION: assert property (@(posedge clk) disable iff (rst)
    !(shift_i && capt_i)); // R8
endmodule

// File: rtl/twopat_ctrl.sv
`timescale 1ns/1ps
module twopat_ctrl
  import twopat_pkg::*;
#(
  parameter  int MAX_LEN = 64,
  parameter  int IDLE_W  = 4,
  parameter  int NPAT_W  = 4,
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int CNT_W   = (LEN_W > IDLE_W) ? LEN_W : IDLE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_in,
  input  logic              mode_in,
  input  logic [IDLE_W-1:0] idle_in,
  input  logic [NPAT_W-1:0] npat_in,
  output logic [LEN_W-1:0]  len_o,
  output logic              shift_o,
  output logic              capt_o,
  output logic              ce_o,
  output logic              scan_en_o,
  output logic              launch_o,
  output logic              capture_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, len_m1, idle_m1;
  logic [NPAT_W-1:0] pat_q, pat_d;
  launch_mode_e      mode_q;
  logic [IDLE_W-1:0] idle_q;
  logic [LEN_W-1:0]  len_clamped;
  logic              done_d, shift_d, capt_d;

  assign len_m1  = CNT_W'(len_o) - 1'b1;
  assign idle_m1 = CNT_W'(idle_q) - 1'b1;

  always_comb begin
    if (len_in == '0)                     len_clamped = LEN_W'(1);
    else if (len_in > LEN_W'(MAX_LEN))    len_clamped = LEN_W'(MAX_LEN);
    else                                  len_clamped = len_in;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pat_d   = pat_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_LOAD;
          cnt_d   = '0;
          pat_d   = (npat_in == '0) ? NPAT_W'(1) : npat_in;
        end
      end
      ST_LOAD: begin
        if (cnt_q == len_m1) begin
          cnt_d   = '0;
          state_d = (mode_q == LAUNCH_CAPT && idle_q != '0) ? ST_GAP : ST_LAUNCH;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_q == idle_m1) begin
          cnt_d   = '0;
          state_d = ST_LAUNCH;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_LAUNCH: state_d = ST_CAPT;
      ST_CAPT: begin
        cnt_d   = '0;
        pat_d   = pat_q - 1'b1;
        state_d = (pat_q == NPAT_W'(1)) ? ST_FLUSH : ST_LOAD;
      end
      ST_FLUSH: begin
        if (cnt_q == len_m1) begin
          cnt_d   = '0;
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign shift_d = (state_d == ST_LOAD) || (state_d == ST_FLUSH) ||
                   ((state_d == ST_LAUNCH) && (mode_q == LAUNCH_SHIFT));
  assign capt_d  = (state_d == ST_CAPT) ||
                   ((state_d == ST_LAUNCH) && (mode_q == LAUNCH_CAPT));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      pat_q     <= '0;
      mode_q    <= LAUNCH_SHIFT;
      idle_q    <= '0;
      len_o     <= LEN_W'(1);
      shift_o   <= 1'b0;
      capt_o    <= 1'b0;
      ce_o      <= 1'b0;
      scan_en_o <= 1'b1;
      launch_o  <= 1'b0;
      capture_o <= 1'b0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pat_q   <= pat_d;
      if (state_q == ST_IDLE && start) begin
        len_o  <= len_clamped;
        mode_q <= launch_mode_e'(mode_in);
        idle_q <= idle_in;
      end
      shift_o   <= shift_d;
      capt_o    <= capt_d;
      ce_o      <= shift_d | capt_d;
      scan_en_o <= shift_d | (state_d == ST_IDLE);
      launch_o  <= (state_d == ST_LAUNCH);
      capture_o <= (state_d == ST_CAPT);
      busy_o    <= (state_d != ST_IDLE);
      done_o    <= done_d;
    end
  end

  AST_CAPT_FOLLOWS_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    launch_o |=> capture_o); // R7
  AST_SE_LOW_AT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    capture_o |-> (!scan_en_o && ce_o)); // R4
  AST_SHIFT_LAUNCH_SE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (launch_o && mode_q == LAUNCH_SHIFT) |-> (scan_en_o && shift_o)); // R3
  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GAP) |-> (!ce_o && !scan_en_o)); // R5
  AST_SE_BACK_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    capture_o |=> (scan_en_o && shift_o)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R10
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> ($stable(len_o) && $stable(idle_q) && $stable(mode_q))); // R11
endmodule

// File: rtl/twopat_seq.sv
`timescale 1ns/1ps
module twopat_seq #(
  parameter  int MAX_LEN = 64,
  parameter  int IDLE_W  = 4,
  parameter  int NPAT_W  = 4,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  pat_len,
  input  logic              launch_mode,
  input  logic [IDLE_W-1:0] idle_cycles,
  input  logic [NPAT_W-1:0] pat_count,
  input  logic              scan_in,
  output logic              scan_out,
  output logic              scan_en,
  output logic              chain_ce,
  output logic              launch,
  output logic              capture,
  output logic              busy,
  output logic              done
);
  logic [LEN_W-1:0]   len_act;
  logic               do_shift, do_capt;
  logic [MAX_LEN-1:0] cells, func_next;

  twopat_ctrl #(
    .MAX_LEN(MAX_LEN),
    .IDLE_W (IDLE_W),
    .NPAT_W (NPAT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .len_in   (pat_len),
    .mode_in  (launch_mode),
    .idle_in  (idle_cycles),
    .npat_in  (pat_count),
    .len_o    (len_act),
    .shift_o  (do_shift),
    .capt_o   (do_capt),
    .ce_o     (chain_ce),
    .scan_en_o(scan_en),
    .launch_o (launch),
    .capture_o(capture),
    .busy_o   (busy),
    .done_o   (done)
  );

  twopat_cut #(.W(MAX_LEN)) u_cut (
    .cells_i(cells),
    .nxt_o  (func_next)
  );

  twopat_chain #(.MAX_LEN(MAX_LEN)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .shift_i (do_shift),
    .capt_i  (do_capt),
    .scan_in (scan_in),
    .len_i   (len_act),
    .func_i  (func_next),
    .cells_o (cells),
    .scan_out(scan_out)
  );
endmodule

// File: tb/test_twopat_seq.sv
`timescale 1ns/1ps
module test_twopat_seq;
  localparam int M  = 64;
  localparam int LW = 7;
  localparam int IW = 4;
  localparam int NW = 4;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, mode = 1'b0, sin = 1'b0;
  logic [LW-1:0] plen = '0;
  logic [IW-1:0] idl  = '0;
  logic [NW-1:0] npat = '0;
  logic sout, se_o, ce_o, ln_o, cp_o, bz_o, dn_o;

  int n_chk = 0, n_fail = 0, elen = 1;
  logic [M-1:0]  model = '0;
  logic [15:0]   lfsr  = 16'hACE1;

  always #2.5 clk = ~clk;

  twopat_seq i_twopat_seq (
    .clk(clk), .rst(rst), .start(start), .pat_len(plen), .launch_mode(mode),
    .idle_cycles(idl), .pat_count(npat), .scan_in(sin), .scan_out(sout),
    .scan_en(se_o), .chain_ce(ce_o), .launch(ln_o), .capture(cp_o),
    .busy(bz_o), .done(dn_o)
  );

  function automatic logic [M-1:0] cut_next(input logic [M-1:0] c);
    logic [M-1:0] r;
    for (int i = 0; i < M; i++) r[i] = c[(i+1)%M] ^ (c[i] & c[(i+2)%M]);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit st, input bit se, input bit ce, input bit ln,
                      input bit cp, input bit bz, input bit dn, input string req);
    @(negedge clk);
    start = st;
    sin   = lfsr[0];
    lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    chk(se_o == se, req, "scan_en",  int'(se_o), int'(se));
    chk(ce_o == ce, req, "chain_ce", int'(ce_o), int'(ce));
    chk(ln_o == ln, req, "launch",   int'(ln_o), int'(ln));
    chk(cp_o == cp, req, "capture",  int'(cp_o), int'(cp));
    chk(bz_o == bz, req, "busy",     int'(bz_o), int'(bz));
    chk(dn_o == dn, req, "done",     int'(dn_o), int'(dn));
    chk(sout == model[elen-1], "R8", "scan_out", int'(sout), int'(model[elen-1]));
    if (ce) model = se ? {model[M-2:0], sin} : cut_next(model);
  endtask

  task automatic run(input int len, input bit md, input int gap, input int np,
                     input bit poke, input string tg);
    int el, pats;
    el   = (len == 0) ? 1 : ((len > M) ? M : len);
    pats = (np == 0) ? 1 : np;
    plen = LW'(len); mode = md; idl = IW'(gap); npat = NW'(np);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    elen = el;
    for (int p = 0; p < pats; p++) begin
      for (int i = 0; i < el; i++) begin
        if (poke && p == 0 && i == 1) begin
          plen = 7'd3; mode = ~md; idl = 4'd9; npat = 4'd7;
          step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R11");
        end else begin
          step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, (p == 0) ? tg : "R9");
        end
      end
      if (!md) begin
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, (gap != 0) ? "R6" : "R3");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
      end else begin
        for (int g = 0; g < gap; g++)
          step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
      end
    end
    for (int i = 0; i < el; i++)
      step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R10");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
  endtask

  task automatic test_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
  endtask

  task automatic test_shift_launch;      run(8, 1'b0, 5, 2, 1'b0, "R2");  endtask
  task automatic test_capt_launch_poke;  run(8, 1'b1, 3, 2, 1'b1, "R2");  endtask
  task automatic test_capt_no_gap;       run(5, 1'b1, 0, 1, 1'b0, "R2");  endtask
  task automatic test_len_one;           run(1, 1'b0, 0, 3, 1'b0, "R12"); endtask
  task automatic test_len_max;           run(64, 1'b1, 2, 1, 1'b0, "R12"); endtask
  task automatic test_len_zero_npat_zero; run(0, 1'b1, 1, 0, 1'b0, "R12"); endtask
  task automatic test_len_over;          run(100, 1'b0, 0, 2, 1'b0, "R12"); endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_shift_launch();
    test_capt_launch_poke();
    test_capt_no_gap();
    test_len_one();
    test_len_max();
    test_len_zero_npat_zero();
    test_len_over();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule